// File: doc/BRIEF.md
# Serial Link Break Sequencer

This block produces the reset pattern for a two-wire clocked serial link, where one wire is the master clock and the other is a bidirectional data line. The link clock is not generated here. The block emits a one-cycle clock-enable strobe for each link clock. A clock generator downstream turns those strobes into clock edges.

Each time the block leaves reset, it runs a flush of free-running link clocks with the data line driven high. This clears stale bits out of the slave. After the flush, the block stays quiet until a start pulse arrives. A start pulse launches four phases in a fixed order:

1. The line idles high.
2. The line is held low for a long stretch. This is the break itself.
3. A short echo phase follows with the line high.
4. A long recovery phase follows with the line high, so the slave logic can reinitialise.

Every phase length is counted in link clocks. A system-clock divider sets how many system cycles make up one link clock. The block drives the data line and its drive enable only while a sequence runs. It signals completion with a one-cycle done pulse.

Top module: `link_break_seq`

## Requirements
- R1: After reset, the block runs a flush phase at once. During the flush, busy_o=1, data_oe_o=1 and data_o=1, and exactly FLUSH_CLKS strobes appear on link_clk_en_o. The block then goes idle, and done_o does not pulse.
- R2: While idle, busy_o=0, data_oe_o=0, link_clk_en_o=0, data_o=1 and done_o=0, apart from the done pulse of R8.
- R3: When start_i=1 is sampled while idle, busy_o=1 in the next cycle. The pre-break phase then drives data_o=1 for PRE_CLKS strobes.
- R4: The break phase drives data_o=0 with data_oe_o=1 for exactly BRK_CLKS strobes.
- R5: The echo phase drives data_o=1 for ECHO_CLKS strobes.
- R6: The recovery phase drives data_o=1 for RECOV_CLKS strobes. A full sequence therefore contains PRE_CLKS+BRK_CLKS+ECHO_CLKS+RECOV_CLKS strobes.
- R7: While busy, link_clk_en_o is high for one cycle in every CLK_DIV cycles. The first strobe of each phase falls on that phase's CLK_DIV-th cycle.
- R8: done_o is high for exactly one cycle. That cycle is the first cycle after the last recovery strobe, and busy_o=0 in it. A start pulse in that same cycle is accepted.
- R9: A start pulse that arrives while busy_o=1, whether during the flush or a break sequence, has no effect on the outputs or on the timing of the sequence.
- R10: While busy, data_o changes only in the cycle that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run a break sequence |
| link_clk_en_o | output | 1 | One-cycle strobe per link clock |
| data_o | output | 1 | Level for the data line |
| data_oe_o | output | 1 | Drive enable for the data line |
| busy_o | output | 1 | A flush or break sequence is running |
| done_o | output | 1 | One-cycle pulse when a break sequence ends |

## Verification
The bench shrinks the phase lengths to 7 for the flush, 5 for pre-break, 9 for the break, 3 for echo and 11 for recovery. It sets the divider to 3. With these values, a whole break sequence takes 84 cycles. That is short enough to run several sequences in one run:

- a start issued mid-flush, which must be ignored;
- a start issued mid-break, which must be ignored;
- a start issued back to back with done;
- a reset issued mid-sequence.

The odd divider tests whether strobe spacing and phase boundaries line up, which a divider of 1 would hide.

// File: rtl/link_break_pkg.sv
package link_break_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FLUSH = 3'd1,
    PH_PRE   = 3'd2,
    PH_BRK   = 3'd3,
    PH_ECHO  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;

  // Line level driven during a phase: low only in the break stretch.
  function automatic logic phase_level(phase_e p);
    return (p != PH_BRK);
  endfunction

  // Fixed phase order; flush and recovery both return to idle.
  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_PRE:   return PH_BRK;
      PH_BRK:   return PH_ECHO;
      PH_ECHO:  return PH_RECOV;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Number of bits needed to hold the value v (at least 1).
  function automatic int bits_for(int v);
    int w;
    w = 1;
    for (int i = 1; i < 31; i++) begin
      if ((1 << i) <= v) w = i + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/lbs_tick_div.sv
module lbs_tick_div #(
  parameter int CLK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (!run_i || div_q == LAST) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end

      assign tick_o = run_i && (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lbs_phase_fsm.sv
module lbs_phase_fsm
  import link_break_pkg::*;
#(
  parameter int FLUSH_CLKS = 5000,
  parameter int PRE_CLKS   = 50,
  parameter int BRK_CLKS   = 256,
  parameter int ECHO_CLKS  = 16,
  parameter int RECOV_CLKS = 16000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   last_o,
  output logic   done_o
);

  localparam int MAX_LEN = max_of(max_of(max_of(FLUSH_CLKS, PRE_CLKS),
                                         max_of(BRK_CLKS, ECHO_CLKS)),
                                  RECOV_CLKS);
  localparam int CNT_W = bits_for(MAX_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] len_of(phase_e p);
    case (p)
      PH_FLUSH: return CNT_W'(FLUSH_CLKS);
      PH_PRE:   return CNT_W'(PRE_CLKS);
      PH_BRK:   return CNT_W'(BRK_CLKS);
      PH_ECHO:  return CNT_W'(ECHO_CLKS);
      PH_RECOV: return CNT_W'(RECOV_CLKS);
      default:  return '0;
    endcase
  endfunction

  phase_e           phase_q;
  phase_e           phase_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_w;

  assign phase_nxt = phase_after(phase_q);
  assign last_w    = (phase_q != PH_IDLE) && tick_i && (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FLUSH;
      cnt_q   <= len_of(PH_FLUSH);
      done_q  <= 1'b0;
    end else begin
      done_q <= last_w && (phase_q == PH_RECOV);
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_PRE;
          cnt_q   <= len_of(PH_PRE);
        end
      end else if (tick_i) begin
        if (cnt_q == CNT_ONE) begin
          phase_q <= phase_nxt;
          cnt_q   <= len_of(phase_nxt);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign last_o  = last_w;
  assign done_o  = done_q;

endmodule

// File: rtl/link_break_seq.sv
module link_break_seq
  import link_break_pkg::*;
#(
  parameter int FLUSH_CLKS = 5000,
  parameter int PRE_CLKS   = 50,
  parameter int BRK_CLKS   = 256,
  parameter int ECHO_CLKS  = 16,
  parameter int RECOV_CLKS = 16000,
  parameter int CLK_DIV    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic link_clk_en_o,
  output logic data_o,
  output logic data_oe_o,
  output logic busy_o,
  output logic done_o
);

  phase_e phase_w;
  logic   run_w;
  logic   tick_w;
  logic   phase_last;
  logic   done_w;

  assign run_w = (phase_w != PH_IDLE);

  lbs_tick_div #(
    .CLK_DIV (CLK_DIV)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .tick_o (tick_w)
  );

  lbs_phase_fsm #(
    .FLUSH_CLKS (FLUSH_CLKS),
    .PRE_CLKS   (PRE_CLKS),
    .BRK_CLKS   (BRK_CLKS),
    .ECHO_CLKS  (ECHO_CLKS),
    .RECOV_CLKS (RECOV_CLKS)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick_w),
    .phase_o (phase_w),
    .last_o  (phase_last),
    .done_o  (done_w)
  );

  assign link_clk_en_o = tick_w;
  assign data_o        = phase_level(phase_w);
  assign data_oe_o     = run_w;
  assign busy_o        = run_w;
  assign done_o        = done_w;

endmodule

// File: rtl/link_break_seq_chk.sv
module link_break_seq_chk #(
  parameter int CLK_DIV = 1
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic clk_en,
  input logic data,
  input logic oe,
  input logic busy,
  input logic done,
  input logic phase_end
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!clk_en && data)); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (busy && data)); // R3

  AST_LOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !data |-> oe); // R4

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((CLK_DIV > 1) && clk_en) |=> !clk_en); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(phase_end))); // R8

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_end) |=> busy); // R9

  AST_DATA_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (data != $past(data))) |-> $past(clk_en)); // R10

endmodule

bind link_break_seq link_break_seq_chk #(
  .CLK_DIV (CLK_DIV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .clk_en    (link_clk_en_o),
  .data      (data_o),
  .oe        (data_oe_o),
  .busy      (busy_o),
  .done      (done_o),
  .phase_end (phase_last)
);

// File: tb/test_link_break_seq.sv
module test_link_break_seq;

  localparam int FL = 7;
  localparam int PR = 5;
  localparam int BK = 9;
  localparam int EC = 3;
  localparam int RC = 11;
  localparam int DV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic en, dat, oe, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  link_break_seq #(
    .FLUSH_CLKS (FL), .PRE_CLKS (PR), .BRK_CLKS (BK),
    .ECHO_CLKS (EC), .RECOV_CLKS (RC), .CLK_DIV (DV)
  ) i_link_break_seq (
    .clk (clk), .rst_n (rst_n), .start_i (start),
    .link_clk_en_o (en), .data_o (dat), .data_oe_o (oe),
    .busy_o (busy), .done_o (done)
  );

  // Reference model: kind 0 = idle, 1 = flush, 2 = break sequence.
  int kind = 1;
  int t = 0;
  bit m_done = 1'b0;
  bit ign = 1'b0;

  function automatic int nseg(int k);
    return (k == 1) ? 1 : ((k == 2) ? 4 : 0);
  endfunction

  function automatic int seg_len(int k, int idx);
    if (k == 1) return FL;
    case (idx)
      0: return PR;
      1: return BK;
      2: return EC;
      default: return RC;
    endcase
  endfunction

  function automatic int total(int k);
    int s = 0;
    for (int i = 0; i < nseg(k); i++) s += seg_len(k, i) * DV;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      kind = 1; t = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (kind != 0) begin
        t++;
        if (t >= total(kind)) begin
          m_done = (kind == 2);
          kind = 0; t = 0; ign = 1'b0;
        end
      end else if (start) begin
        kind = 2; t = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison and strobe counting, away from the active edge.
  int prev_kind = 1;
  int fl_cnt = 0, bk_cnt = 0, seq_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      fl_cnt = 0; bk_cnt = 0; seq_cnt = 0; prev_kind = 1;
    end else begin
      int ph, off, acc;
      bit e_en, e_dat, e_busy;
      string tg;
      ph = -1; off = 0; acc = 0;
      for (int i = 0; i < nseg(kind); i++) begin
        if (ph < 0 && t < acc + seg_len(kind, i) * DV) begin
          ph = i; off = t - acc;
        end
        acc += seg_len(kind, i) * DV;
      end
      e_busy = (kind != 0);
      e_en   = e_busy && ((off % DV) == DV - 1);
      e_dat  = !(kind == 2 && ph == 1);
      if (kind == 0) tg = "R2";
      else if (kind == 1) tg = "R1";
      else if (ph == 0) tg = "R3";
      else if (ph == 1) tg = "R4";
      else if (ph == 2) tg = "R5";
      else tg = "R6";
      if (ign) tg = {tg, " R9"};
      check({tg, " busy"}, busy, e_busy);
      check({tg, " oe"}, oe, e_busy);
      check({tg, " R10 data"}, dat, e_dat);
      check({tg, " R7 strobe"}, en, e_en);
      check({tg, " R8 done"}, done, m_done);
      if (en && kind == 1) fl_cnt++;
      if (en && kind == 2) seq_cnt++;
      if (en && kind == 2 && !dat) bk_cnt++;
      if (prev_kind == 1 && kind == 0) begin
        check("R1 flush strobe count", fl_cnt, FL);
        fl_cnt = 0;
      end
      if (done) begin
        check("R4 break strobe count", bk_cnt, BK);
        check("R6 sequence strobe count", seq_cnt, PR + BK + EC + RC);
        bk_cnt = 0; seq_cnt = 0;
      end
      prev_kind = kind;
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: flush running in the first cycle
    check("R1 busy after reset", busy, 1);
    check("R1 data after reset", dat, 1);
    repeat (5) @(negedge clk);
    // R9: start during flush is ignored
    ign = 1'b1;
    pulse_start();
    wait_idle();
    repeat (4) @(negedge clk);
    // R3..R6 full sequence
    pulse_start();
    repeat (PR * DV + 4) @(negedge clk);
    // R9: start during break is ignored
    ign = 1'b1;
    pulse_start();
    while (!done) @(negedge clk);
    // R8: start in the done cycle is accepted
    pulse_start();
    check("R8 back-to-back accepted", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    // Reset in mid-sequence restarts with a flush (R1)
    pulse_start();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 flush after reset", busy, 1);
    wait_idle();
    repeat (5) @(negedge clk);
    pulse_start();
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule